// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block is a fully associative translation buffer for a 32-bit virtual address space. Every entry describes a pair of adjacent virtual pages, even and odd, and gives each half its own physical frame and its own attribute bits: valid, dirty, read-inhibit and execute-inhibit. A lookup is purely combinational. The block takes a virtual address, an access kind and the current 8-bit address-space identifier, and it returns a physical address, a writable flag and a result code in the same cycle.

Entries are loaded one at a time through a write port. The port takes an index and every field of the entry, and the entry is replaced at the next clock edge. Page size is set per entry by a 16-bit mask that widens the page above the 4 KiB minimum. The surrounding pipeline owns the replacement choice, the page-table walk and all fault reporting. It acts on the result code only.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is marked invalidated, so any lookup returns result code 1 (no-match), with `pa_o` at zero and `writable_o` at 0.
- R2: An entry hits when three conditions hold. Its invalidation bit is clear. Its global bit is set, or its 8-bit identifier equals `asid_i`. Virtual address bits [31:13] equal the entry's page-pair number in every position not covered by the page mask.
- R3: Mask bit k covers virtual address bit 13+k. The only legal masks are contiguous runs of ones starting at bit 0. The half of the pair is picked by the address bit just above the offset: bit 12 for a zero mask, and bit 12+n for a mask of n ones. A set bit selects the odd half.
- R4: On a hit, a clear valid bit in the selected half gives result code 2 (invalid). The valid bit is checked before any other attribute bit.
- R5: The access kind is encoded as 0 fetch, 1 load, 2 store and 3 load. On a valid half, a fetch with execute-inhibit set gives code 5. A load with read-inhibit set gives code 4. Read-inhibit has no effect on fetches or stores, and execute-inhibit has no effect on loads or stores.
- R6: A store to a valid half with its dirty bit clear gives code 3 (modify). Every other access that reaches this step gives code 0 (match).
- R7: With code 0, `pa_o` is the selected frame number shifted left by 12, ORed with the virtual address bits below the selected single-page size. `writable_o` equals the half's dirty bit. With any other code, `pa_o` is 0 and `writable_o` is 0.
- R8: When several entries hit, the entry with the lowest index decides the result.
- R9: A write loads the whole entry at `wr_idx_i` on one clock edge. Lookups after that edge see the new contents.
- R10: When no entry hits, the result is code 1 (no-match).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| va_i | input | 32 | Virtual address to translate |
| acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| asid_i | input | 8 | Current address-space identifier |
| wr_en_i | input | 1 | Load an entry on this clock edge |
| wr_idx_i | input | 4 | Index of the entry to load |
| wr_vpn2_i | input | 19 | Page-pair number, virtual address bits [31:13] |
| wr_mask_i | input | 16 | Page mask; bit k covers address bit 13+k |
| wr_asid_i | input | 8 | Identifier of the entry |
| wr_glob_i | input | 1 | Global bit: the entry ignores the identifier compare |
| wr_inval_i | input | 1 | Invalidation bit: the entry never hits |
| wr_pfn0_i | input | 20 | Frame number of the even half |
| wr_pfn1_i | input | 20 | Frame number of the odd half |
| wr_attr0_i | input | 4 | Even-half attributes {xi, ri, dirty, valid} |
| wr_attr1_i | input | 4 | Odd-half attributes {xi, ri, dirty, valid} |
| pa_o | output | 32 | Translated physical address |
| writable_o | output | 1 | The translated page may be written |
| result_o | output | 3 | 0 match, 1 no-match, 2 invalid, 3 modify, 4 read-inhibit, 5 execute-inhibit |

## Verification
The hardest case to reach is two entries that hit together, with the lowest-index winner then removed so that the next entry takes over. The stimulus builds this on purpose. It loads the same global page pair into two neighbouring slots with different frames, then rewrites the lower slot with its invalidation bit set. Large pages come next: an entry with a full mask moves the half-select bit up to bit 28, which catches offset and select logic that only works at 4 KiB. A random phase then packs entries into a small virtual window with mixed masks and identifiers, so that overlapping hits and every attribute combination appear under all four access kinds.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W   = 32;
  parameter int PA_W   = 32;
  parameter int ASID_W = 8;
  parameter int MASK_W = 16;
  parameter int OFF_W  = 12;
  parameter int N_ENT  = 16;

  localparam int VPN2_W = VA_W - OFF_W - 1;
  localparam int PFN_W  = PA_W - OFF_W;

  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_NOMATCH = 3'd1,
    RES_INVALID = 3'd2,
    RES_MODIFY  = 3'd3,
    RES_RDINH   = 3'd4,
    RES_EXINH   = 3'd5
  } tlb_res_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_LOAD2 = 2'd3
  } tlb_acc_e;

  typedef struct packed {
    logic xi;
    logic ri;
    logic dirty;
    logic valid;
  } half_attr_t;

  typedef struct packed {
    logic [VPN2_W-1:0]           vpn2;
    logic [MASK_W-1:0]           mask;
    logic [ASID_W-1:0]           asid;
    logic                        glob;
    logic                        inval;
    logic [1:0][PFN_W-1:0]       pfn;
    half_attr_t [1:0]            attr;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int N      = N_ENT,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  tlb_entry_t            wr_ent_i,
  output tlb_entry_t [N-1:0]    ent_o
);
  tlb_entry_t [N-1:0] ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        ent_q[i]       <= '0;
        ent_q[i].inval <= 1'b1;
      end
    end else if (wr_en_i) begin
      ent_q[wr_idx_i] <= wr_ent_i;
    end
  end

  assign ent_o = ent_q;

  p_write_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ent_o[$past(wr_idx_i)] == $past(wr_ent_i));
endmodule

// File: rtl/tlb_match_row.sv
module tlb_match_row
  import tlb_pkg::*;
(
  input  tlb_entry_t        ent_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              hit_o,
  output logic [PA_W-1:0]   pa_o,
  output half_attr_t        attr_o
);
  localparam int HI_PAD = VA_W - MASK_W - OFF_W - 1;

  logic [VA_W-1:0]   span, off_mask, half_bit;
  logic [VPN2_W-1:0] vpn_diff;
  logic              odd;

  // span covers the whole pair; its top bit picks the half
  assign span     = {{HI_PAD{1'b0}}, ent_i.mask, {(OFF_W+1){1'b1}}};
  assign off_mask = span >> 1;
  assign half_bit = span & ~off_mask;
  assign vpn_diff = (va_i[VA_W-1:OFF_W+1] ^ ent_i.vpn2) & ~span[VA_W-1:OFF_W+1];
  assign hit_o    = ~|vpn_diff && !ent_i.inval && (ent_i.glob || ent_i.asid == asid_i);
  assign odd      = |(va_i & half_bit);
  assign attr_o   = ent_i.attr[odd];
  assign pa_o     = {ent_i.pfn[odd], {OFF_W{1'b0}}} | PA_W'(va_i & off_mask);
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick
  import tlb_pkg::*;
#(
  parameter int N      = N_ENT,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N-1:0]              hit_i,
  input  logic [N-1:0][PA_W-1:0]    pa_i,
  input  half_attr_t [N-1:0]        attr_i,
  output logic                      any_o,
  output logic [PA_W-1:0]           pa_o,
  output half_attr_t                attr_o
);
  logic [IDX_W-1:0] sel;

  always_comb begin
    any_o = 1'b0;
    sel   = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  assign pa_o   = pa_i[sel];
  assign attr_o = attr_i[sel];

  p_lowest_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (hit_i[sel] && ((hit_i & ((N'(1) << sel) - N'(1))) == '0)));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int N      = N_ENT,
  localparam int IDX_W = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [VA_W-1:0]    va_i,
  input  logic [1:0]         acc_i,
  input  logic [ASID_W-1:0]  asid_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [VPN2_W-1:0]  wr_vpn2_i,
  input  logic [MASK_W-1:0]  wr_mask_i,
  input  logic [ASID_W-1:0]  wr_asid_i,
  input  logic               wr_glob_i,
  input  logic               wr_inval_i,
  input  logic [PFN_W-1:0]   wr_pfn0_i,
  input  logic [PFN_W-1:0]   wr_pfn1_i,
  input  logic [3:0]         wr_attr0_i,
  input  logic [3:0]         wr_attr1_i,
  output logic [PA_W-1:0]    pa_o,
  output logic               writable_o,
  output logic [2:0]         result_o
);
  tlb_entry_t                wr_ent;
  tlb_entry_t [N-1:0]        ents;
  logic [N-1:0]              hits;
  logic [N-1:0][PA_W-1:0]    row_pa;
  half_attr_t [N-1:0]        row_attr;
  logic                      any_hit;
  logic [PA_W-1:0]           sel_pa;
  half_attr_t                sel_attr;
  tlb_acc_e                  acc;
  tlb_res_e                  res;

  always_comb begin
    wr_ent         = '0;
    wr_ent.vpn2    = wr_vpn2_i;
    wr_ent.mask    = wr_mask_i;
    wr_ent.asid    = wr_asid_i;
    wr_ent.glob    = wr_glob_i;
    wr_ent.inval   = wr_inval_i;
    wr_ent.pfn[0]  = wr_pfn0_i;
    wr_ent.pfn[1]  = wr_pfn1_i;
    wr_ent.attr[0] = half_attr_t'(wr_attr0_i);
    wr_ent.attr[1] = half_attr_t'(wr_attr1_i);
  end

  tlb_entry_store #(.N(N)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_ent_i (wr_ent),
    .ent_o    (ents)
  );

  for (genvar g = 0; g < N; g++) begin : g_row
    tlb_match_row u_row (
      .ent_i  (ents[g]),
      .va_i   (va_i),
      .asid_i (asid_i),
      .hit_o  (hits[g]),
      .pa_o   (row_pa[g]),
      .attr_o (row_attr[g])
    );
  end

  tlb_pick #(.N(N)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hits),
    .pa_i   (row_pa),
    .attr_i (row_attr),
    .any_o  (any_hit),
    .pa_o   (sel_pa),
    .attr_o (sel_attr)
  );

  assign acc = tlb_acc_e'(acc_i);

  // fixed check order: valid, execute-inhibit, read-inhibit, dirty
  always_comb begin
    if (!any_hit)                                            res = RES_NOMATCH;
    else if (!sel_attr.valid)                                res = RES_INVALID;
    else if (acc == ACC_FETCH && sel_attr.xi)                res = RES_EXINH;
    else if ((acc == ACC_LOAD || acc == ACC_LOAD2) && sel_attr.ri) res = RES_RDINH;
    else if (acc == ACC_STORE && !sel_attr.dirty)            res = RES_MODIFY;
    else                                                     res = RES_MATCH;
  end

  assign result_o   = res;
  assign pa_o       = (res == RES_MATCH) ? sel_pa : '0;
  assign writable_o = (res == RES_MATCH) && sel_attr.dirty;

  p_mask_contig_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> ((wr_mask_i & (wr_mask_i + MASK_W'(1))) == '0));
  p_nohit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hits == '0) |-> (result_o == 3'(RES_NOMATCH)));
  p_writable_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    writable_o |-> (result_o == 3'(RES_MATCH)));
  p_rdinh_not_fetch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o == 3'(RES_RDINH)) |-> (acc_i != 2'(ACC_FETCH)));
endmodule

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [31:0] va;
  logic [1:0]  acc;
  logic [7:0]  asid;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [18:0] wr_vpn2;
  logic [15:0] wr_mask;
  logic [7:0]  wr_asid;
  logic        wr_glob, wr_inval;
  logic [19:0] wr_pfn0, wr_pfn1;
  logic [3:0]  wr_attr0, wr_attr1;
  logic [31:0] pa_o;
  logic        writable_o;
  logic [2:0]  result_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model of programmed entries
  logic [18:0] m_vpn  [16];
  logic [15:0] m_mask [16];
  logic [7:0]  m_asid [16];
  logic        m_g    [16];
  logic        m_inv  [16];
  logic [19:0] m_pfn  [16][2];
  logic [3:0]  m_f    [16][2];

  always #2 clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk_i(clk), .rst_ni(rst_ni), .va_i(va), .acc_i(acc), .asid_i(asid),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_vpn2_i(wr_vpn2), .wr_mask_i(wr_mask),
    .wr_asid_i(wr_asid), .wr_glob_i(wr_glob), .wr_inval_i(wr_inval),
    .wr_pfn0_i(wr_pfn0), .wr_pfn1_i(wr_pfn1), .wr_attr0_i(wr_attr0), .wr_attr1_i(wr_attr1),
    .pa_o(pa_o), .writable_o(writable_o), .result_o(result_o)
  );

  function automatic void ref_look(input logic [31:0] a, input logic [1:0] k,
                                   input logic [7:0] cur, output logic [2:0] res,
                                   output logic [31:0] p, output logic w);
    bit found = 0;
    res = 3'd1; p = '0; w = 1'b0;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] span, tag;
      logic [3:0]  f;
      int          h;
      span = ({16'h0, m_mask[i]} << 13) | 32'h1fff;
      tag  = {13'h0, m_vpn[i]} << 13;
      if (!found && !m_inv[i] && (m_g[i] || m_asid[i] == cur) &&
          ((a & ~span) == (tag & ~span))) begin
        found = 1;
        h = ((a & ((span >> 1) + 32'd1)) != 0) ? 1 : 0;
        f = m_f[i][h];
        if (!f[0])                 res = 3'd2;
        else if (k == 2'd0 && f[3]) res = 3'd5;
        else if (k[0] && f[2])     res = 3'd4;
        else if (k == 2'd2 && !f[1]) res = 3'd3;
        else                       res = 3'd0;
        if (res == 3'd0) begin
          p = ({12'h0, m_pfn[i][h]} << 12) | (a & (span >> 1));
          w = f[1];
        end
      end
    end
  endfunction

  task automatic cyc(input string tag);
    logic [2:0]  er;
    logic [31:0] ep;
    logic        ew;
    #1;
    ref_look(va, acc, asid, er, ep, ew);
    checks++;
    if (result_o !== er || pa_o !== ep || writable_o !== ew) begin
      fails++;
      $display("FAIL %s: va=%h acc=%0d res=%0d pa=%h wr=%b expected res=%0d pa=%h wr=%b",
               tag, va, acc, result_o, pa_o, writable_o, er, ep, ew);
    end
    @(posedge clk);
    if (wr_en && rst_ni) begin
      m_vpn[wr_idx] = wr_vpn2; m_mask[wr_idx] = wr_mask; m_asid[wr_idx] = wr_asid;
      m_g[wr_idx] = wr_glob; m_inv[wr_idx] = wr_inval;
      m_pfn[wr_idx][0] = wr_pfn0; m_pfn[wr_idx][1] = wr_pfn1;
      m_f[wr_idx][0] = wr_attr0; m_f[wr_idx][1] = wr_attr1;
    end
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] a, input logic [1:0] k, input logic [7:0] s,
                      input string tag);
    va = a; acc = k; asid = s; wr_en = 1'b0;
    cyc(tag);
  endtask

  task automatic load(input int idx, input logic [18:0] vpn, input logic [15:0] msk,
                      input logic [7:0] s, input logic g, input logic inv,
                      input logic [19:0] p0, input logic [19:0] p1,
                      input logic [3:0] f0, input logic [3:0] f1);
    wr_idx = 4'(idx); wr_vpn2 = vpn; wr_mask = msk; wr_asid = s; wr_glob = g;
    wr_inval = inv; wr_pfn0 = p0; wr_pfn1 = p1; wr_attr0 = f0; wr_attr1 = f1;
    wr_en = 1'b1;
    cyc("R9 write cycle");
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_vpn[i] = '0; m_mask[i] = '0; m_asid[i] = '0; m_g[i] = 0; m_inv[i] = 1;
      m_pfn[i][0] = '0; m_pfn[i][1] = '0; m_f[i][0] = '0; m_f[i][1] = '0;
    end
    rst_ni = 1'b0; va = '0; acc = '0; asid = '0; wr_en = 1'b0; wr_idx = '0;
    wr_vpn2 = '0; wr_mask = '0; wr_asid = '0; wr_glob = 0; wr_inval = 0;
    wr_pfn0 = '0; wr_pfn1 = '0; wr_attr0 = '0; wr_attr1 = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    look(32'h0000_0000, 2'd1, 8'd0, "R1 reset lookup zero");
    look(32'h0002_0abc, 2'd0, 8'd5, "R1 reset lookup fetch");
    look(32'hffff_f000, 2'd2, 8'd0, "R1 reset lookup store");

    // 4 KiB pair, non-global, asid 5
    load(0, 19'h10, 16'h0, 8'd5, 0, 0, 20'h11111, 20'h22222, 4'b0011, 4'b0001);
    look(32'h0002_0abc, 2'd1, 8'd5, "R2 R7 even load hit");
    look(32'h0002_1abc, 2'd1, 8'd5, "R3 R7 odd half by bit 12");
    look(32'h0002_1abc, 2'd2, 8'd5, "R6 store clean half modify");
    look(32'h0002_0abc, 2'd2, 8'd5, "R6 store dirty half match");
    look(32'h0002_0abc, 2'd1, 8'd6, "R2 R10 asid mismatch");

    // 16 KiB pair, global with asid 9, inhibit bits
    load(1, 19'h200, 16'h0003, 8'd9, 1, 0, 20'h30000, 20'h40000, 4'b1011, 4'b0101);
    look(32'h0040_3123, 2'd0, 8'd3, "R5 fetch execute-inhibit");
    look(32'h0040_3123, 2'd1, 8'd3, "R2 R5 global load ignores xi");
    look(32'h0040_3123, 2'd2, 8'd3, "R5 store ignores xi");
    look(32'h0040_5123, 2'd1, 8'd3, "R3 R5 odd by bit 14 read-inhibit");
    look(32'h0040_5123, 2'd3, 8'd3, "R5 alt load read-inhibit");
    look(32'h0040_5123, 2'd0, 8'd3, "R5 fetch ignores ri");
    look(32'h0040_5123, 2'd2, 8'd3, "R5 R6 store ignores ri modify");

    // invalid half checked first
    load(2, 19'h400, 16'h0, 8'd0, 1, 0, 20'h55555, 20'h66666, 4'b1110, 4'b0011);
    look(32'h0080_0010, 2'd0, 8'd0, "R4 invalid before xi");
    look(32'h0080_0010, 2'd1, 8'd0, "R4 invalid before ri");
    look(32'h0080_0010, 2'd2, 8'd0, "R4 invalid store");
    look(32'h0080_1010, 2'd2, 8'd0, "R4 odd half valid");

    // invalidation bit
    load(3, 19'h600, 16'h0, 8'd0, 1, 1, 20'h77777, 20'h77777, 4'b0011, 4'b0011);
    look(32'h00c0_0000, 2'd1, 8'd0, "R2 R10 invalidated entry");

    // priority between overlapping entries
    load(5, 19'h800, 16'h0, 8'd0, 1, 0, 20'hbbbbb, 20'hccccc, 4'b0011, 4'b0011);
    load(4, 19'h800, 16'h0, 8'd0, 1, 0, 20'h99999, 20'haaaaa, 4'b0001, 4'b0001);
    look(32'h0100_0fff, 2'd1, 8'd0, "R8 lowest index wins");
    look(32'h0100_0fff, 2'd2, 8'd0, "R8 lowest index attributes");
    load(4, 19'h800, 16'h0, 8'd0, 1, 1, 20'h99999, 20'haaaaa, 4'b0001, 4'b0001);
    look(32'h0100_0fff, 2'd2, 8'd0, "R8 R9 next entry after rewrite");

    // full-size mask
    load(6, 19'h10000, 16'hffff, 8'd0, 1, 0, 20'h80000, 20'h90000, 4'b0011, 4'b0001);
    look(32'h2000_1234, 2'd1, 8'd0, "R3 R7 big page even");
    look(32'h3abc_1234, 2'd1, 8'd0, "R3 R7 big page odd bit 28");
    look(32'h4000_1234, 2'd1, 8'd0, "R10 outside big page");

    // random phase
    for (int n = 0; n < 600; n++) begin
      if (($urandom % 4) == 0) begin
        int k;
        k = $urandom % 5;
        wr_idx   = 4'($urandom % 16);
        wr_vpn2  = 19'($urandom % 64);
        wr_mask  = 16'((1 << k) - 1);
        wr_asid  = 8'($urandom % 4);
        wr_glob  = (($urandom % 4) == 0);
        wr_inval = (($urandom % 8) == 0);
        wr_pfn0  = 20'($urandom);
        wr_pfn1  = 20'($urandom);
        wr_attr0 = 4'($urandom);
        wr_attr1 = 4'($urandom);
        wr_en    = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
      va   = ((32'($urandom % 64)) << 13) | (32'($urandom) & 32'h1fff);
      acc  = 2'($urandom % 4);
      asid = 8'($urandom % 4);
      cyc("R2 R3 R8 random");
    end
    wr_en = 1'b0;

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule